// File: doc/BRIEF.md
# Outstanding Cache Request Tracker

This block sits between a processor-side request port and a cache controller and records which cache lines have a request in flight. Each incoming request carries a byte address, an operation (read, write or flush) and optional qualifiers: instruction fetch, locked access, linked-load/conditional-store pairing and a store-check hint. The block sorts the request into a read class or a write class. It compares the line address with every live entry and then does one of three things: it accepts the request and forwards it downstream, it refuses it because the line is already busy, or it refuses it because too many requests are outstanding.

Accepted requests are stamped with a free-running cycle count. When the controller reports a completed line and class, the matching entry is released and the elapsed cycle count is reported together with the request type that was recorded. A periodic watchdog runs only while entries are live and raises a sticky error once any entry has been outstanding for a configurable number of cycles. A completion that matches no live entry raises a separate sticky error. Four counters record alias refusals, one for each pairing of new class against the class of the blocking entry.

The request and forward interfaces are valid/ready. A request is taken on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a forwarded request is held in the output register and `iss_ready` is low. A forwarded request holds `iss_addr` and `iss_type` stable until it is taken. The status pulse, the completion input and the latency report have no back-pressure.

Top module: `req_tracker`

## Requirements
- R1: A request taken while the outstanding count is at or above MAX_OUT gets status 2 (full), is not forwarded and does not change any counter. This check comes before the alias check. The outstanding count never exceeds MAX_OUT.
- R2: Loads (`req_op`=0 with no qualifier, or with `req_ifetch`) are read class. Every other request is write class, including stores (`req_op`=1), flushes (`req_op`=2 or 3), store-check reads, locked accesses and linked/conditional accesses. A completion releases an entry only when `cpl_wr` equals the entry's class (1 = write class).
- R3: A request whose line matches any live entry of either class gets status 1 (aliased) and is neither forwarded nor stored. An accepted request gets status 0.
- R4: Matching uses the line address: the address with its low log2(LINE_BYTES) bits ignored, where LINE_BYTES defaults to 64. `iss_addr` carries the full request address.
- R5: The forwarded type codes are: load 0, instruction fetch 1, store 2, flush 8, linked/conditional 9. A locked read or write, and a read with `req_stchk`, are forwarded as store 2. Precedence is linked/conditional, then locked, then plain. Among plain reads, instruction fetch takes precedence over store-check.
- R6: On a matching completion, `lat_valid` pulses for one cycle after the completion edge. `lat_cycles` then equals the number of clock edges from the accepting edge to the completion edge. `lat_type` gives the recorded type: load 0, fetch 1, store 2, store-check read 3, linked load 4, conditional store 5, locked read 6, locked write 7, flush 8.
- R7: A matching completion frees its entry, so the same line is then accepted again. A completion that matches no live entry of its class leaves all entries unchanged and sets `cpl_err`, which stays high until reset.
- R8: `dl_err` is set, and stays set, when a periodic check finds an entry aged at least DL_THRESH cycles. The check runs every DL_THRESH cycles only while entries are live. An entry younger than DL_THRESH never sets it.
- R9: `occ_count` equals the number of live entries. It is 0 after reset.
- R10: Each alias refusal adds one to exactly one counter, chosen by the new request's class and the blocking entry's class: write-on-read `cnt_wr_on_rd`, write-on-write `cnt_wr_on_wr`, read-on-write `cnt_rd_on_wr`, read-on-read `cnt_rd_on_rd`.
- R11: While `iss_valid` is high and `iss_ready` is low, `req_ready` is low and `iss_addr` and `iss_type` hold their values. No request is taken during that time.
- R12: `st_valid` pulses high for exactly one cycle after each request handshake edge, and at no other time. `st_code` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | ADDR_W | Request byte address |
| req_op | input | 2 | 0 read, 1 write, 2/3 flush |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_lock | input | 1 | Locked read-modify-write access |
| req_llsc | input | 1 | Linked load / conditional store |
| req_stchk | input | 1 | Read that intends to write |
| st_valid | output | 1 | Status pulse |
| st_code | output | 2 | 0 accepted, 1 aliased, 2 full |
| iss_valid | output | 1 | Forwarded request present |
| iss_ready | input | 1 | Downstream takes forwarded request |
| iss_addr | output | ADDR_W | Forwarded address |
| iss_type | output | 4 | Forwarded type code |
| cpl_valid | input | 1 | Completion present |
| cpl_line | input | ADDR_W-log2(LINE_BYTES) | Completed line address |
| cpl_wr | input | 1 | Completion class, 1 = write |
| lat_valid | output | 1 | Latency report pulse |
| lat_type | output | 4 | Recorded type of freed entry |
| lat_cycles | output | TS_W | Miss latency in cycles |
| occ_count | output | log2(MAX_OUT+1) | Live entries |
| cpl_err | output | 1 | Sticky unmatched completion |
| dl_err | output | 1 | Sticky deadlock detection |
| cnt_wr_on_rd | output | STAT_W | Write refused by read entry |
| cnt_wr_on_wr | output | STAT_W | Write refused by write entry |
| cnt_rd_on_wr | output | STAT_W | Read refused by write entry |
| cnt_rd_on_rd | output | STAT_W | Read refused by read entry |

## Verification
The main test sends every qualifier combination one at a time against an idle table. It checks both the forwarded type and the recorded type, which separates the precedence of the three classification paths. Alias tests pair each class against a live entry of each class. They use addresses that differ only in offset bits and then addresses that differ by one line, so that line masking, the cross-class lookup and the counter selection are each observed on their own. Filling the table shows that the full condition takes precedence over an alias. Holding the forward interface stalled shows that requests wait instead of being lost. A completion with the wrong class is also tested, to show that class takes part in matching.

// File: rtl/req_tracker_pkg.sv
package req_tracker_pkg;

  // Request type codes: stored per entry and reported on release
  typedef enum logic [3:0] {
    RT_LD     = 4'd0,
    RT_IFETCH = 4'd1,
    RT_ST     = 4'd2,
    RT_RMW_RD = 4'd3,
    RT_LL     = 4'd4,
    RT_SC     = 4'd5,
    RT_LK_RD  = 4'd6,
    RT_LK_WR  = 4'd7,
    RT_FLUSH  = 4'd8,
    RT_ATOMIC = 4'd9
  } rt_type_e;

  typedef enum logic [1:0] {
    RT_OK    = 2'd0,
    RT_ALIAS = 2'd1,
    RT_FULL  = 2'd2
  } rt_status_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;

endpackage

// File: rtl/rt_classify.sv
module rt_classify
  import req_tracker_pkg::*;
(
  input  logic [1:0] op,
  input  logic       ifetch,
  input  logic       lock,
  input  logic       llsc,
  input  logic       stchk,
  output rt_type_e   prim_type,
  output rt_type_e   fwd_type,
  output logic       is_wr
);

  logic rd_op;
  logic wr_op;

  always_comb begin
    rd_op = (op == OP_READ);
    wr_op = (op == OP_WRITE);
    if (llsc) begin
      prim_type = rd_op ? RT_LL : RT_SC;
      fwd_type  = RT_ATOMIC;
    end else if (lock) begin
      prim_type = rd_op ? RT_LK_RD : RT_LK_WR;
      fwd_type  = RT_ST;
    end else if (rd_op) begin
      if (ifetch) begin
        prim_type = RT_IFETCH;
        fwd_type  = RT_IFETCH;
      end else if (stchk) begin
        prim_type = RT_RMW_RD;
        fwd_type  = RT_ST;
      end else begin
        prim_type = RT_LD;
        fwd_type  = RT_LD;
      end
    end else if (wr_op) begin
      prim_type = RT_ST;
      fwd_type  = RT_ST;
    end else begin
      prim_type = RT_FLUSH;
      fwd_type  = RT_FLUSH;
    end
    is_wr = !((prim_type == RT_LD) || (prim_type == RT_IFETCH));
  end

endmodule

// File: rtl/rt_table.sv
module rt_table
  import req_tracker_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 26,
  parameter int TS_W  = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  // lookup of the incoming request
  input  logic [TAG_W-1:0]            lk_tag,
  output logic                        lk_hit,
  output logic                        lk_hit_wr,
  output logic                        free_any,
  // allocation
  input  logic                        alloc_en,
  input  logic                        alloc_wr,
  input  rt_type_e                    alloc_type,
  input  logic [TS_W-1:0]             alloc_ts,
  // completion
  input  logic                        cpl_en,
  input  logic [TAG_W-1:0]            cpl_tag,
  input  logic                        cpl_wr,
  output logic                        cpl_hit,
  output rt_type_e                    cpl_type,
  output logic [TS_W-1:0]             cpl_ts,
  // state view for the watchdog
  output logic [DEPTH-1:0]            vld_vec,
  output logic [DEPTH-1:0]            wr_vec,
  output logic [DEPTH-1:0][TS_W-1:0]  ts_vec
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0]             wr_q;
  logic [DEPTH-1:0][TAG_W-1:0]  tag_q;
  logic [DEPTH-1:0][TS_W-1:0]   ts_q;
  rt_type_e                     type_q [DEPTH];

  logic [DEPTH-1:0] lk_m;
  logic [DEPTH-1:0] cp_m;
  logic [IW-1:0]    free_idx;
  logic [IW-1:0]    cpl_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign lk_m[g] = vld_q[g] && (tag_q[g] == lk_tag);
    assign cp_m[g] = vld_q[g] && (wr_q[g] == cpl_wr) && (tag_q[g] == cpl_tag);
  end

  assign lk_hit    = |lk_m;
  assign lk_hit_wr = |(lk_m & wr_q);
  assign cpl_hit   = |cp_m;

  // lowest-index free slot
  always_comb begin
    free_idx = '0;
    free_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        free_idx = IW'(i);
        free_any = 1'b1;
      end
    end
  end

  // at most one live entry can match a completion
  always_comb begin
    cpl_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (cp_m[i]) cpl_idx = IW'(i);
    end
  end

  assign cpl_type = type_q[cpl_idx];
  assign cpl_ts   = ts_q[cpl_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (cpl_en && cpl_hit) vld_q[cpl_idx] <= 1'b0;
      if (alloc_en && free_any) vld_q[free_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en && free_any) begin
      wr_q[free_idx]   <= alloc_wr;
      tag_q[free_idx]  <= lk_tag;
      ts_q[free_idx]   <= alloc_ts;
      type_q[free_idx] <= alloc_type;
    end
  end

  assign vld_vec = vld_q;
  assign wr_vec  = wr_q;
  assign ts_vec  = ts_q;

endmodule

// File: rtl/rt_watchdog.sv
module rt_watchdog #(
  parameter int DEPTH  = 8,
  parameter int TS_W   = 16,
  parameter int THRESH = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TS_W-1:0]             now,
  input  logic [DEPTH-1:0]            vld_vec,
  input  logic [DEPTH-1:0][TS_W-1:0]  ts_vec,
  output logic                        dl_err
);

  localparam int PW = $clog2(THRESH + 1);

  logic [PW-1:0] per_q;
  logic          any_old;
  logic          live;
  logic          chk_now;
  logic [TS_W-1:0] age;

  always_comb begin
    any_old = 1'b0;
    age     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      age = now - ts_vec[i];
      if (vld_vec[i] && (age >= TS_W'(THRESH))) any_old = 1'b1;
    end
  end

  assign live    = |vld_vec;
  assign chk_now = (per_q == PW'(THRESH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      dl_err <= 1'b0;
    end else begin
      if (!live || chk_now) per_q <= '0;
      else                  per_q <= per_q + 1'b1;
      if (live && chk_now && any_old) dl_err <= 1'b1;
    end
  end

endmodule

// File: rtl/req_tracker.sv
module req_tracker
  import req_tracker_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int LINE_BYTES = 64,
  parameter  int DEPTH      = 8,
  parameter  int MAX_OUT    = 6,
  parameter  int TS_W       = 16,
  parameter  int DL_THRESH  = 64,
  parameter  int STAT_W     = 16,
  localparam int OFS_W      = $clog2(LINE_BYTES),
  localparam int TAG_W      = ADDR_W - OFS_W,
  localparam int OCC_W      = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_op,
  input  logic              req_ifetch,
  input  logic              req_lock,
  input  logic              req_llsc,
  input  logic              req_stchk,
  output logic              st_valid,
  output logic [1:0]        st_code,
  output logic              iss_valid,
  input  logic              iss_ready,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [3:0]        iss_type,
  input  logic              cpl_valid,
  input  logic [TAG_W-1:0]  cpl_line,
  input  logic              cpl_wr,
  output logic              lat_valid,
  output logic [3:0]        lat_type,
  output logic [TS_W-1:0]   lat_cycles,
  output logic [OCC_W-1:0]  occ_count,
  output logic              cpl_err,
  output logic              dl_err,
  output logic [STAT_W-1:0] cnt_wr_on_rd,
  output logic [STAT_W-1:0] cnt_wr_on_wr,
  output logic [STAT_W-1:0] cnt_rd_on_wr,
  output logic [STAT_W-1:0] cnt_rd_on_rd
);

  rt_type_e        prim_type;
  rt_type_e        fwd_type;
  logic            req_wr;
  logic            lk_hit;
  logic            lk_hit_wr;
  logic            free_any;
  logic            cpl_hit;
  rt_type_e        cpl_type;
  logic [TS_W-1:0] cpl_ts;
  logic [DEPTH-1:0]           vld_vec;
  logic [DEPTH-1:0]           wr_vec;
  logic [DEPTH-1:0][TS_W-1:0] ts_vec;

  logic [TS_W-1:0]  now_q;
  logic [OCC_W-1:0] occ_q;
  logic             iss_vq;
  logic             fire;
  logic             is_full;
  logic             accept;
  logic             alias_ev;
  logic             cpl_free;

  rt_classify u_cls (
    .op        (req_op),
    .ifetch    (req_ifetch),
    .lock      (req_lock),
    .llsc      (req_llsc),
    .stchk     (req_stchk),
    .prim_type (prim_type),
    .fwd_type  (fwd_type),
    .is_wr     (req_wr)
  );

  rt_table #(.DEPTH(DEPTH), .TAG_W(TAG_W), .TS_W(TS_W)) u_tbl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_tag     (req_addr[ADDR_W-1:OFS_W]),
    .lk_hit     (lk_hit),
    .lk_hit_wr  (lk_hit_wr),
    .free_any   (free_any),
    .alloc_en   (accept),
    .alloc_wr   (req_wr),
    .alloc_type (prim_type),
    .alloc_ts   (now_q),
    .cpl_en     (cpl_valid),
    .cpl_tag    (cpl_line),
    .cpl_wr     (cpl_wr),
    .cpl_hit    (cpl_hit),
    .cpl_type   (cpl_type),
    .cpl_ts     (cpl_ts),
    .vld_vec    (vld_vec),
    .wr_vec     (wr_vec),
    .ts_vec     (ts_vec)
  );

  rt_watchdog #(.DEPTH(DEPTH), .TS_W(TS_W), .THRESH(DL_THRESH)) u_wdg (
    .clk     (clk),
    .rst_n   (rst_n),
    .now     (now_q),
    .vld_vec (vld_vec),
    .ts_vec  (ts_vec),
    .dl_err  (dl_err)
  );

  assign req_ready = !iss_vq || iss_ready;
  assign fire      = req_valid && req_ready;
  assign is_full   = (occ_q >= OCC_W'(MAX_OUT)) || !free_any;
  assign accept    = fire && !is_full && !lk_hit;
  assign alias_ev  = fire && !is_full && lk_hit;
  assign cpl_free  = cpl_valid && cpl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      now_q    <= '0;
      occ_q    <= '0;
      st_valid <= 1'b0;
      st_code  <= RT_OK;
      iss_vq   <= 1'b0;
      iss_addr <= '0;
      iss_type <= '0;
      lat_valid  <= 1'b0;
      lat_type   <= '0;
      lat_cycles <= '0;
      cpl_err  <= 1'b0;
    end else begin
      now_q    <= now_q + 1'b1;
      occ_q    <= occ_q + OCC_W'(accept) - OCC_W'(cpl_free);
      st_valid <= fire;
      if (fire) st_code <= is_full ? RT_FULL : (lk_hit ? RT_ALIAS : RT_OK);
      if (accept) begin
        iss_vq   <= 1'b1;
        iss_addr <= req_addr;
        iss_type <= fwd_type;
      end else if (iss_ready) begin
        iss_vq   <= 1'b0;
      end
      lat_valid <= cpl_free;
      if (cpl_free) begin
        lat_type   <= cpl_type;
        lat_cycles <= now_q - cpl_ts;
      end
      if (cpl_valid && !cpl_hit) cpl_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_wr_on_rd <= '0;
      cnt_wr_on_wr <= '0;
      cnt_rd_on_wr <= '0;
      cnt_rd_on_rd <= '0;
    end else if (alias_ev) begin
      case ({req_wr, lk_hit_wr})
        2'b10:   cnt_wr_on_rd <= cnt_wr_on_rd + 1'b1;
        2'b11:   cnt_wr_on_wr <= cnt_wr_on_wr + 1'b1;
        2'b01:   cnt_rd_on_wr <= cnt_rd_on_wr + 1'b1;
        default: cnt_rd_on_rd <= cnt_rd_on_rd + 1'b1;
      endcase
    end
  end

  assign iss_valid = iss_vq;
  assign occ_count = occ_q;

endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
  parameter int ADDR_W  = 32,
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 6,
  parameter int OCC_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              st_valid,
  input logic [1:0]        st_code,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [ADDR_W-1:0] iss_addr,
  input logic [3:0]        iss_type,
  input logic              cpl_valid,
  input logic              lat_valid,
  input logic [OCC_W-1:0]  occ_count,
  input logic              lk_hit,
  input logic [DEPTH-1:0]  vld_vec,
  input logic              cpl_err,
  input logic              dl_err
);

  AST_FULL_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && (32'($past(occ_count)) >= MAX_OUT)) |-> (st_code == 2'd2)); // R1

  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_count) <= MAX_OUT); // R1

  AST_ACCEPT_NO_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_code == 2'd0) |-> !$past(lk_hit)); // R3

  AST_ACCEPT_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_code == 2'd0) |-> iss_valid); // R5

  AST_LAT_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    lat_valid |-> $past(cpl_valid)); // R6

  AST_CPL_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cpl_err) |-> cpl_err); // R7

  AST_DL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dl_err) |-> dl_err); // R8

  AST_OCC_MATCHES_ENTRIES: assert property (@(posedge clk) disable iff (!rst_n)
    32'(occ_count) == $countones(vld_vec)); // R9

  AST_STALL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |-> !req_ready); // R11

  AST_ISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=> (iss_valid && $stable(iss_addr) && $stable(iss_type))); // R11

  AST_STATUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> $past(req_valid && req_ready)); // R12

endmodule

bind req_tracker rt_checker #(
  .ADDR_W  (ADDR_W),
  .DEPTH   (DEPTH),
  .MAX_OUT (MAX_OUT),
  .OCC_W   (OCC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .st_valid  (st_valid),
  .st_code   (st_code),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .iss_addr  (iss_addr),
  .iss_type  (iss_type),
  .cpl_valid (cpl_valid),
  .lat_valid (lat_valid),
  .occ_count (occ_count),
  .lk_hit    (lk_hit),
  .vld_vec   (vld_vec),
  .cpl_err   (cpl_err),
  .dl_err    (dl_err)
);

// File: tb/req_tracker_tb.sv
module req_tracker_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic        req_ifetch = 1'b0;
  logic        req_lock = 1'b0;
  logic        req_llsc = 1'b0;
  logic        req_stchk = 1'b0;
  logic        st_valid;
  logic [1:0]  st_code;
  logic        iss_valid;
  logic        iss_ready = 1'b1;
  logic [31:0] iss_addr;
  logic [3:0]  iss_type;
  logic        cpl_valid = 1'b0;
  logic [25:0] cpl_line = '0;
  logic        cpl_wr = 1'b0;
  logic        lat_valid;
  logic [3:0]  lat_type;
  logic [15:0] lat_cycles;
  logic [2:0]  occ_count;
  logic        cpl_err;
  logic        dl_err;
  logic [15:0] cnt_wr_on_rd, cnt_wr_on_wr, cnt_rd_on_wr, cnt_rd_on_rd;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  req_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_op(req_op), .req_ifetch(req_ifetch), .req_lock(req_lock),
    .req_llsc(req_llsc), .req_stchk(req_stchk),
    .st_valid(st_valid), .st_code(st_code),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_addr(iss_addr), .iss_type(iss_type),
    .cpl_valid(cpl_valid), .cpl_line(cpl_line), .cpl_wr(cpl_wr),
    .lat_valid(lat_valid), .lat_type(lat_type), .lat_cycles(lat_cycles),
    .occ_count(occ_count), .cpl_err(cpl_err), .dl_err(dl_err),
    .cnt_wr_on_rd(cnt_wr_on_rd), .cnt_wr_on_wr(cnt_wr_on_wr),
    .cnt_rd_on_wr(cnt_rd_on_wr), .cnt_rd_on_rd(cnt_rd_on_rd)
  );

  task automatic chk(input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // drive one request at a negedge, sample one negedge later
  task automatic req_chk(input string tag, input logic [31:0] a, input logic [1:0] op,
                         input bit f_if, input bit f_lk, input bit f_ll, input bit f_sc,
                         input int exp_code, input int exp_type);
    req_valid = 1'b1; req_addr = a; req_op = op;
    req_ifetch = f_if; req_lock = f_lk; req_llsc = f_ll; req_stchk = f_sc;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R12 status pulse"}, st_valid, 1);
    chk({tag, " status code"}, st_code, exp_code);
    if (exp_code == 0) begin
      chk({tag, " R5 forwarded"}, iss_valid, 1);
      chk({tag, " R5 forwarded type"}, iss_type, exp_type);
      chk({tag, " R4 forwarded address"}, iss_addr, a);
    end else begin
      chk({tag, " R3 refused not forwarded"}, iss_valid, 0);
    end
  endtask

  task automatic cpl_chk(input string tag, input logic [31:0] a, input bit wr,
                         input bit exp_hit, input int exp_lat, input int exp_type);
    cpl_valid = 1'b1; cpl_line = a[31:6]; cpl_wr = wr;
    @(negedge clk);
    cpl_valid = 1'b0;
    chk({tag, " R7 completion match"}, lat_valid, exp_hit);
    if (exp_hit && exp_lat >= 0) chk({tag, " R6 latency"}, lat_cycles, exp_lat);
    if (exp_hit && exp_type >= 0) chk({tag, " R6 recorded type"}, lat_type, exp_type);
  endtask

  task automatic t_reset;
    chk("R9 reset occupancy", occ_count, 0);
    chk("R12 reset status", st_valid, 0);
    chk("R11 reset ready", req_ready, 1);
    chk("R7 reset cpl_err", cpl_err, 0);
    chk("R8 reset dl_err", dl_err, 0);
    chk("R10 reset counters", cnt_wr_on_rd + cnt_wr_on_wr + cnt_rd_on_wr + cnt_rd_on_rd, 0);
  endtask

  task automatic t_types;
    req_chk("R5 load", 32'h100, 2'd0, 0, 0, 0, 0, 0, 0);
    cpl_chk("R2 load read class", 32'h100, 0, 1, 1, 0);
    req_chk("R5 fetch", 32'h140, 2'd0, 1, 0, 0, 1, 0, 1);
    cpl_chk("R2 fetch read class", 32'h140, 0, 1, 1, 1);
    req_chk("R5 store-check read", 32'h180, 2'd0, 0, 0, 0, 1, 0, 2);
    cpl_chk("R2 store-check write class", 32'h180, 1, 1, 1, 3);
    req_chk("R5 store", 32'h1C0, 2'd1, 0, 0, 0, 0, 0, 2);
    cpl_chk("R2 store write class", 32'h1C0, 1, 1, 1, 2);
    req_chk("R5 flush", 32'h200, 2'd2, 0, 0, 0, 0, 0, 8);
    cpl_chk("R2 flush write class", 32'h200, 1, 1, 1, 8);
    req_chk("R5 linked load", 32'h240, 2'd0, 1, 1, 1, 1, 0, 9);
    cpl_chk("R2 linked load write class", 32'h240, 1, 1, 1, 4);
    req_chk("R5 conditional store", 32'h280, 2'd1, 0, 0, 1, 0, 0, 9);
    cpl_chk("R2 conditional store write class", 32'h280, 1, 1, 1, 5);
    req_chk("R5 locked read", 32'h2C0, 2'd0, 1, 1, 0, 1, 0, 2);
    cpl_chk("R2 locked read write class", 32'h2C0, 1, 1, 1, 6);
    req_chk("R5 locked write", 32'h300, 2'd1, 0, 1, 0, 0, 0, 2);
    cpl_chk("R2 locked write write class", 32'h300, 1, 1, 1, 7);
    chk("R9 types drained", occ_count, 0);
  endtask

  task automatic t_alias;
    req_chk("R3 load A", 32'h1234, 2'd0, 0, 0, 0, 0, 0, 0);
    req_chk("R4 load A other offset", 32'h1208, 2'd0, 0, 0, 0, 0, 1, 0);
    chk("R10 read-on-read", cnt_rd_on_rd, 1);
    req_chk("R4 store A last byte", 32'h123F, 2'd1, 0, 0, 0, 0, 1, 0);
    chk("R10 write-on-read", cnt_wr_on_rd, 1);
    req_chk("R4 next line accepted", 32'h1240, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R9 two live", occ_count, 2);
    cpl_chk("R7 free A", 32'h1200, 0, 1, -1, 0);
    req_chk("R7 A accepted again", 32'h1200, 2'd1, 0, 0, 0, 0, 0, 2);
    req_chk("R3 load on store", 32'h1210, 2'd0, 0, 0, 0, 0, 1, 0);
    chk("R10 read-on-write", cnt_rd_on_wr, 1);
    req_chk("R3 store on store", 32'h1204, 2'd1, 0, 0, 0, 0, 1, 0);
    req_chk("R3 flush on store", 32'h1200, 2'd2, 0, 0, 0, 0, 1, 0);
    chk("R10 write-on-write", cnt_wr_on_wr, 2);
    chk("R10 read-on-read unchanged", cnt_rd_on_rd, 1);
    cpl_chk("R7 free A store", 32'h1200, 1, 1, -1, 2);
    cpl_chk("R7 free next line", 32'h1240, 0, 1, -1, 0);
    chk("R9 alias drained", occ_count, 0);
  endtask

  task automatic t_latency;
    req_chk("R6 load", 32'h4000, 2'd0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    cpl_chk("R6 delayed", 32'h4000, 0, 1, 6, 0);
    req_chk("R6 store", 32'h4040, 2'd1, 0, 0, 0, 0, 0, 2);
    cpl_chk("R6 immediate", 32'h4040, 1, 1, 1, 2);
  endtask

  task automatic t_full;
    for (int i = 0; i < 6; i++)
      req_chk("R1 fill", 32'h8000 + 32'(i) * 32'h40, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R9 six live", occ_count, 6);
    req_chk("R1 new line refused full", 32'h9000, 2'd0, 0, 0, 0, 0, 2, 0);
    req_chk("R1 full before alias", 32'h8000, 2'd0, 0, 0, 0, 0, 2, 0);
    chk("R1 counter untouched", cnt_rd_on_rd, 1);
    chk("R1 occupancy unchanged", occ_count, 6);
    cpl_chk("R1 free one", 32'h8000, 0, 1, -1, 0);
    req_chk("R1 accepted after free", 32'h9000, 2'd0, 0, 0, 0, 0, 0, 0);
    for (int i = 1; i < 6; i++)
      cpl_chk("R7 drain", 32'h8000 + 32'(i) * 32'h40, 0, 1, -1, 0);
    cpl_chk("R7 drain last", 32'h9000, 0, 1, -1, 0);
    chk("R9 full drained", occ_count, 0);
  endtask

  task automatic t_backpressure;
    iss_ready = 1'b0;
    req_chk("R11 first", 32'h3000, 2'd0, 0, 0, 0, 0, 0, 0);
    chk("R11 ready low", req_ready, 0);
    req_valid = 1'b1; req_addr = 32'h3040; req_op = 2'd1;
    req_ifetch = 0; req_lock = 0; req_llsc = 0; req_stchk = 0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk("R12 no status while stalled", st_valid, 0);
      chk("R11 address held", iss_addr, 32'h3000);
      chk("R11 type held", iss_type, 0);
      chk("R11 still not ready", req_ready, 0);
    end
    iss_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 taken after release", st_valid, 1);
    chk("R11 accepted", st_code, 0);
    chk("R11 next forwarded", iss_addr, 32'h3040);
    chk("R11 next type", iss_type, 2);
    @(negedge clk);
    chk("R12 single pulse", st_valid, 0);
    chk("R11 forward drained", iss_valid, 0);
    cpl_chk("R7 bp free", 32'h3000, 0, 1, -1, 0);
    cpl_chk("R7 bp free", 32'h3040, 1, 1, -1, 2);
  endtask

  task automatic t_cpl_err;
    req_chk("R2 store", 32'h5040, 2'd1, 0, 0, 0, 0, 0, 2);
    cpl_chk("R2 wrong class", 32'h5040, 0, 0, -1, -1);
    chk("R7 error set", cpl_err, 1);
    chk("R2 entry kept", occ_count, 1);
    cpl_chk("R7 unknown line", 32'h5000, 1, 0, -1, -1);
    cpl_chk("R2 right class", 32'h5040, 1, 1, -1, 2);
    chk("R7 error sticky", cpl_err, 1);
  endtask

  task automatic t_deadlock;
    chk("R8 quiet so far", dl_err, 0);
    req_chk("R8 load", 32'h6000, 2'd0, 0, 0, 0, 0, 0, 0);
    repeat (40) @(negedge clk);
    chk("R8 young entry", dl_err, 0);
    repeat (100) @(negedge clk);
    chk("R8 old entry flagged", dl_err, 1);
    cpl_chk("R8 free", 32'h6000, 0, 1, 141, 0);
    repeat (3) @(negedge clk);
    chk("R8 sticky", dl_err, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_types();
    t_alias();
    t_latency();
    t_full();
    t_backpressure();
    t_cpl_err();
    t_deadlock();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule